// File: doc/BRIEF.md
# Clock-Loss Stop Supervisor

This block watches for loss of the crystal oscillator while the chip rests in its low-power pseudo-stop state. Two enable bits decide the response to a monitor failure. With the monitor off, the failure is ignored. With the monitor on and self-clocking off, the block asks for an immediate monitor reset. With both on, the block switches to a PLL-based self clock. It powers the regulator and the PLL, latches a sticky failure flag and starts a counted oscillator quality check. A third enable bit decides whether that flag also raises a wakeup request.

The quality check counts oscillator cycles in the oscillator domain. The count restarts whenever the monitor reports failure. A done level returns to the control domain through a two-flop synchronizer and a level handshake. If the check passes while the chip is still stopped, the block quietly returns to plain low-power stop. Stop mode ends on a wakeup interrupt, an external reset or the block's own wakeup request. The system clock selected on exit is the oscillator when the check has passed and the PLL when it has not. After a self-clocked exit, a later pass moves the system clock back to the oscillator.

Top module: `clkloss_stop_sup`

## Requirements
- R1: With `mon_en` = 0, `cm_fail` during stop has no effect: no reset request, no flag, no self clock, and the block stays stopped.
- R2: With `mon_en` = 1 and `scm_en` = 0, `cm_fail` during stop gives a one-cycle `cm_reset_req` on the next cycle and clears `stop_active`.
- R3: With `mon_en` = 1 and `scm_en` = 1, `cm_fail` during stop sets `scm_active`, `pll_en`, `vreg_en` and `fail_flag` on the next cycle.
- R4: `wake_req` equals `fail_flag` AND `scm_irq_en`. With `scm_irq_en` = 0 the block stays stopped after a failure. With it at 1, the wakeup request ends stop.
- R5: A quality check passes `QUAL_CYCLES` (default 4096) oscillator cycles after `cm_fail` falls, plus a few cycles of synchronizer delay. When it passes in stop, `scm_active`, `pll_en` and `vreg_en` fall and `stop_active` stays 1.
- R6: While `cm_fail` stays high, no check ever passes and self clock remains active.
- R7: In stop, `wkup_irq`, `ext_rst` or `wake_req` gives a one-cycle `stop_exit` and clears `stop_active`. `sysclk_sel_pll` (1 = PLL clock, 0 = oscillator clock) becomes 1 exactly when self clock is active at exit.
- R8: `ext_rst` gives a one-cycle `reset_seq_start` on the next cycle. A check that is running when stop is left by self clock keeps running.
- R9: A monitor failure during a running check restarts the count from zero.
- R10: `fail_flag` stays set until a one-cycle `flag_clr` (write-one-to-clear). Clearing it drops `wake_req`.
- R11: A pass outside stop clears `scm_active` and returns `sysclk_sel_pll` to 0.
- R12: `vreg_en` is 1 when not stopped or when self clock is active, and 0 in plain stop. `pll_en` follows `scm_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| osc_clk | input | 1 | Oscillator clock for the quality counter |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| scm_irq_en | input | 1 | Wakeup request enable for the failure flag |
| cm_fail | input | 1 | Monitor failure indication, control domain |
| stop_enter | input | 1 | Pulse that enters pseudo-stop |
| wkup_irq | input | 1 | Wakeup interrupt request |
| ext_rst | input | 1 | External reset request pulse |
| flag_clr | input | 1 | Write-one pulse clearing the failure flag |
| vreg_en | output | 1 | Regulator full-power enable |
| pll_en | output | 1 | PLL enable |
| scm_active | output | 1 | Self-clock mode active |
| fail_flag | output | 1 | Sticky clock failure flag |
| cm_reset_req | output | 1 | Monitor reset request pulse |
| wake_req | output | 1 | Self-clock wakeup request |
| sysclk_sel_pll | output | 1 | System clock select, 1 = PLL |
| stop_exit | output | 1 | Stop-exit strobe |
| stop_active | output | 1 | Pseudo-stop in effect |
| reset_seq_start | output | 1 | Reset sequence start pulse |

## Verification
The assertions assume that `cm_fail` is already synchronous to `clk`, and that `flag_clr`, `ext_rst`, `wkup_irq` and `stop_enter` are single-cycle pulses. The enable bits are held steady while the block is stopped. The stimulus drives every input at the falling edge of `clk` and pulses each strobe for one cycle. It changes the enables only while the block is running. It also keeps each failure pulse several cycles long, so that the handshake settles between a pass and the next failure.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_MRST = 2'd1,
    ACT_SCM  = 2'd2
  } loss_act_e;

  // Response chosen for a monitor failure seen during stop.
  function automatic loss_act_e loss_action(input logic mon, input logic scm);
    if (!mon)     return ACT_NONE;
    else if (!scm) return ACT_MRST;
    else          return ACT_SCM;
  endfunction

  // Final count value of a quality check of the given length.
  function automatic logic qual_at_end(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/clkloss_sync.sv
module clkloss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkloss_qual_cnt.sv
module clkloss_qual_cnt
  import clkloss_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 4096,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic done_o
);
  logic          arm_s;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          at_end;

  clkloss_sync #(.STAGES(SYNC_STAGES)) arm_sync_i (
    .clk(osc_clk), .rst_n(rst_n), .d_i(arm_i), .q_o(arm_s)
  );

  assign at_end = qual_at_end(32'(cnt_q), QUAL_CYCLES);

  // The count is cleared whenever arm is low; done stays up until arm drops.
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!arm_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (at_end) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/clkloss_ctl.sv
module clkloss_ctl
  import clkloss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic scm_en,
  input  logic scm_irq_en,
  input  logic cm_fail,
  input  logic stop_enter,
  input  logic wkup_irq,
  input  logic ext_rst,
  input  logic flag_clr,
  input  logic qual_done_osc,
  output logic arm_o,
  output logic fail_evt_o,
  output logic pass_evt_o,
  output logic exit_evt_o,
  output logic stop_o,
  output logic scm_o,
  output logic flag_o,
  output logic sel_pll_o,
  output logic mrst_o,
  output logic exit_o,
  output logic rseq_o,
  output logic wake_o
);
  loss_act_e act;
  logic stop_q, scm_q, flag_q, sel_q, chk_q, arm_q;
  logic mrst_q, exit_q, rseq_q, done_d;
  logic done_s;
  logic fail_evt, mrst_evt, exit_evt, pass_evt, wake;
  logic stop_n, scm_n, flag_n, sel_n, chk_n;

  clkloss_sync #(.STAGES(SYNC_STAGES)) done_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(qual_done_osc), .q_o(done_s)
  );

  assign act      = loss_action(mon_en, scm_en);
  assign fail_evt = stop_q && cm_fail && (act == ACT_SCM);
  assign mrst_evt = stop_q && cm_fail && (act == ACT_MRST);
  assign wake     = flag_q && scm_irq_en;
  assign exit_evt = stop_q && !mrst_evt && (wake || wkup_irq || ext_rst);
  assign pass_evt = done_s && !done_d && chk_q;

  always_comb begin
    scm_n  = scm_q;
    chk_n  = chk_q;
    flag_n = flag_q;
    sel_n  = sel_q;
    stop_n = stop_q;
    if (fail_evt) begin
      scm_n = 1'b1;
      chk_n = 1'b1;
    end else if (pass_evt) begin
      scm_n = 1'b0;
      chk_n = 1'b0;
    end
    if (fail_evt)      flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    if (!stop_q) stop_n = stop_enter;
    else if (mrst_evt || exit_evt) stop_n = 1'b0;
    if (exit_evt)                 sel_n = scm_n;
    else if (pass_evt && !stop_q) sel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      scm_q  <= 1'b0;
      flag_q <= 1'b0;
      sel_q  <= 1'b0;
      chk_q  <= 1'b0;
      arm_q  <= 1'b0;
      mrst_q <= 1'b0;
      exit_q <= 1'b0;
      rseq_q <= 1'b0;
      done_d <= 1'b0;
    end else begin
      stop_q <= stop_n;
      scm_q  <= scm_n;
      flag_q <= flag_n;
      sel_q  <= sel_n;
      chk_q  <= chk_n;
      arm_q  <= chk_n && !cm_fail;
      mrst_q <= mrst_evt;
      exit_q <= exit_evt;
      rseq_q <= ext_rst;
      done_d <= done_s;
    end
  end

  assign arm_o      = arm_q;
  assign fail_evt_o = fail_evt;
  assign pass_evt_o = pass_evt;
  assign exit_evt_o = exit_evt;
  assign stop_o     = stop_q;
  assign scm_o      = scm_q;
  assign flag_o     = flag_q;
  assign sel_pll_o  = sel_q;
  assign mrst_o     = mrst_q;
  assign exit_o     = exit_q;
  assign rseq_o     = rseq_q;
  assign wake_o     = wake;
endmodule

// File: rtl/clkloss_stop_sup.sv
module clkloss_stop_sup #(
  parameter int unsigned QUAL_CYCLES = 4096,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic scm_en,
  input  logic scm_irq_en,
  input  logic cm_fail,
  input  logic stop_enter,
  input  logic wkup_irq,
  input  logic ext_rst,
  input  logic flag_clr,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_active,
  output logic fail_flag,
  output logic cm_reset_req,
  output logic wake_req,
  output logic sysclk_sel_pll,
  output logic stop_exit,
  output logic stop_active,
  output logic reset_seq_start
);
  logic qual_arm, qual_done, qual_pass, loss_seen, exit_seen;

  clkloss_qual_cnt #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) qual_i (
    .osc_clk(osc_clk), .rst_n(rst_n), .arm_i(qual_arm), .done_o(qual_done)
  );

  clkloss_ctl #(.SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .scm_en(scm_en),
    .scm_irq_en(scm_irq_en), .cm_fail(cm_fail), .stop_enter(stop_enter),
    .wkup_irq(wkup_irq), .ext_rst(ext_rst), .flag_clr(flag_clr),
    .qual_done_osc(qual_done), .arm_o(qual_arm), .fail_evt_o(loss_seen),
    .pass_evt_o(qual_pass), .exit_evt_o(exit_seen), .stop_o(stop_active),
    .scm_o(scm_active), .flag_o(fail_flag), .sel_pll_o(sysclk_sel_pll),
    .mrst_o(cm_reset_req), .exit_o(stop_exit), .rseq_o(reset_seq_start),
    .wake_o(wake_req)
  );

  assign pll_en  = scm_active;
  assign vreg_en = !stop_active || scm_active;
endmodule

// File: rtl/clkloss_stop_sup_chk.sv
module clkloss_stop_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic scm_en,
  input logic cm_fail,
  input logic flag_clr,
  input logic stop_active,
  input logic scm_active,
  input logic fail_flag,
  input logic cm_reset_req,
  input logic sysclk_sel_pll,
  input logic stop_exit,
  input logic qual_pass
);
  // R2
  mrst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_reset_req |-> $past(mon_en && !scm_en && cm_fail && stop_active));

  // R2
  mrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_reset_req |=> !cm_reset_req);

  // R3
  flag_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(mon_en && scm_en && cm_fail && stop_active));

  // R10
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(flag_clr));

  // R7
  exit_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_exit |-> $past(stop_active) && !stop_active);

  // R7
  pll_sel_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_sel_pll) |-> stop_exit);

  // R5
  scm_off_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_active) |-> $past(qual_pass));
endmodule

bind clkloss_stop_sup clkloss_stop_sup_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .scm_en(scm_en), .cm_fail(cm_fail),
  .flag_clr(flag_clr), .stop_active(stop_active), .scm_active(scm_active),
  .fail_flag(fail_flag), .cm_reset_req(cm_reset_req),
  .sysclk_sel_pll(sysclk_sel_pll), .stop_exit(stop_exit), .qual_pass(qual_pass)
);

// File: tb/clkloss_stop_sup_tb.sv
module clkloss_stop_sup_tb_top;
  localparam int unsigned QUAL = 4096;
  localparam int unsigned WIN  = 16;

  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic mon_en = 0, scm_en = 0, scm_irq_en = 0, cm_fail = 0;
  logic stop_enter = 0, wkup_irq = 0, ext_rst = 0, flag_clr = 0;
  logic vreg_en, pll_en, scm_active, fail_flag, cm_reset_req, wake_req;
  logic sysclk_sel_pll, stop_exit, stop_active, reset_seq_start;

  always #4 clk = ~clk;
  always #5 osc_clk = ~osc_clk;

  int osc_n = 0;
  always @(posedge osc_clk) osc_n = osc_n + 1;

  clkloss_stop_sup #(.QUAL_CYCLES(QUAL)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { bit is_mrst; bit sel; } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exit(bit sel);
    exp_t e; e.is_mrst = 0; e.sel = sel; exp_q.push_back(e);
  endtask

  task automatic push_mrst();
    exp_t e; e.is_mrst = 1; e.sel = 0; exp_q.push_back(e);
  endtask

  // Scoreboard monitor: every exit or monitor-reset pulse must match the queue.
  always @(negedge clk) begin
    if (rst_n && (stop_exit || cm_reset_req)) begin
      if (exp_q.size() == 0) begin
        chk("R7", 1, 0, "unexpected exit/reset pulse");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.is_mrst ? "R2" : "R7", int'(cm_reset_req), int'(e.is_mrst), "monitor reset pulse");
        chk("R7", int'(stop_exit), int'(!e.is_mrst), "stop exit pulse");
        if (!e.is_mrst) chk("R7", int'(sysclk_sel_pll), int'(e.sel), "clock select at exit");
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_enter = 1; cyc(1); stop_enter = 0; cyc(1);
  endtask

  task automatic fail_burst(int n);
    cm_fail = 1; cyc(n); cm_fail = 0;
  endtask

  // Wait until self clock drops; return the oscillator count at that moment.
  task automatic wait_scm_low(output int at);
    at = -1;
    for (int i = 0; i < 12000; i++) begin
      if (!scm_active) begin at = osc_n; break; end
      cyc(1);
    end
  endtask

  task automatic chk_window(string req, int d);
    n_chk++;
    if (d < int'(QUAL) || d > int'(QUAL + WIN)) begin
      n_fail++;
      $display("FAIL %s pass latency act=%0d exp=%0d..%0d", req, d, QUAL, QUAL + WIN);
    end
  endtask

  initial begin
    #(200000 * 8 - 800);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t_fall, t_low;
    cyc(4); rst_n = 1; cyc(2);
    // Reset state, R12
    chk("R12", int'(vreg_en), 1, "vreg after reset");
    chk("R12", int'(pll_en), 0, "pll after reset");
    chk("R7", int'(stop_active), 0, "stop after reset");
    chk("R3", int'(fail_flag), 0, "flag after reset");
    chk("R7", int'(sysclk_sel_pll), 0, "select after reset");

    // R1: monitor off, failure ignored
    mon_en = 0; scm_en = 1; scm_irq_en = 1;
    pulse_stop();
    chk("R12", int'(vreg_en), 0, "vreg in plain stop");
    fail_burst(5); cyc(3);
    chk("R1", int'(stop_active), 1, "still stopped");
    chk("R1", int'(fail_flag), 0, "no flag");
    chk("R1", int'(scm_active), 0, "no self clock");
    chk("R1", int'(wake_req), 0, "no wake");
    push_exit(0); wkup_irq = 1; cyc(1); wkup_irq = 0; cyc(2);
    chk("R7", int'(stop_active), 0, "left stop on wakeup");

    // R2: immediate monitor reset
    mon_en = 1; scm_en = 0; scm_irq_en = 0;
    pulse_stop();
    push_mrst(); fail_burst(3); cyc(2);
    chk("R2", int'(stop_active), 0, "stop cleared by monitor reset");
    chk("R2", int'(fail_flag), 0, "no flag on monitor reset");

    // R3/R4/R5: self clock, no interrupt, recovery inside stop
    scm_en = 1;
    pulse_stop();
    cm_fail = 1; cyc(1);
    chk("R3", int'(scm_active), 1, "self clock on");
    chk("R3", int'(pll_en), 1, "pll on");
    chk("R3", int'(vreg_en), 1, "vreg on");
    chk("R3", int'(fail_flag), 1, "flag set");
    cyc(2); cm_fail = 0; t_fall = osc_n; cyc(20);
    chk("R4", int'(stop_active), 1, "stays stopped with irq off");
    chk("R4", int'(wake_req), 0, "no wake with irq off");
    wait_scm_low(t_low);
    chk_window("R5", t_low - t_fall);
    chk("R5", int'(pll_en), 0, "pll off after pass");
    chk("R5", int'(vreg_en), 0, "vreg off after pass");
    chk("R5", int'(stop_active), 1, "still stopped after pass");
    chk("R10", int'(fail_flag), 1, "flag sticky after pass");
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10", int'(fail_flag), 0, "flag cleared");
    push_exit(0); wkup_irq = 1; cyc(1); wkup_irq = 0; cyc(2);

    // R9/R8/R11: restart, exit by external reset in self clock
    pulse_stop();
    fail_burst(3);
    cyc(3750);
    chk("R9", int'(scm_active), 1, "still checking");
    fail_burst(3); t_fall = osc_n;
    cyc(1000);
    push_exit(1); ext_rst = 1; cyc(1); ext_rst = 0;
    chk("R8", int'(reset_seq_start), 1, "reset sequence pulse");
    cyc(1);
    chk("R8", int'(reset_seq_start), 0, "reset sequence pulse ends");
    chk("R8", int'(scm_active), 1, "check continues after exit");
    chk("R7", int'(sysclk_sel_pll), 1, "PLL clock after self-clock exit");
    wait_scm_low(t_low);
    chk_window("R9", t_low - t_fall);
    cyc(1);
    chk("R11", int'(sysclk_sel_pll), 0, "back to oscillator after pass");
    chk("R11", int'(scm_active), 0, "self clock off after pass");
    flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);

    // R4/R6/R10: wakeup by flag, oscillator stays lost
    scm_irq_en = 1;
    pulse_stop();
    push_exit(1); cm_fail = 1; cyc(1);
    chk("R4", int'(wake_req), 1, "wake request raised");
    cyc(3);
    chk("R4", int'(stop_active), 0, "left stop via wake request");
    cyc(6000);
    chk("R6", int'(scm_active), 1, "no pass while failure held");
    chk("R6", int'(sysclk_sel_pll), 1, "PLL clock held");
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10", int'(fail_flag), 0, "flag cleared by write");
    chk("R10", int'(wake_req), 0, "wake request dropped");
    cm_fail = 0;
    wait_scm_low(t_low);
    cyc(1);
    chk("R11", int'(sysclk_sel_pll), 0, "oscillator after recovery");
    cyc(4);
    chk("R7", exp_q.size(), 0, "all expected pulses seen");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule